// File: doc/BRIEF.md
# Peripheral Bus Transaction Monitor

This block watches a simple non-pipelined peripheral bus without driving any of its wires. It sees the select vector, the enable strobe, the direction bit, the address and both data buses. From these it produces one record for every finished transfer. A write is reported from the setup cycle, where the master already presents the write data. A read is reported from the data cycle, where the addressed target presents the read data. Each record carries the direction, the address, the data and the index of the selected target.

In the same pass the block checks the bus handshake and raises one-cycle error flags for three kinds of fault: an illegal phase code, address or direction moving between setup and data cycle, and phase sequences the protocol does not allow.

The record output is a valid-only stream and has no ready input. A passive observer cannot stall the bus it watches, so whatever consumes the records must accept one on every cycle in which the valid pulse is high. At most one record appears per clock, so the consumer's sustained rate is one record per cycle.

Top module: `bus_txn_monitor`

## Requirements
- R1: While `rst` is high, `rec_valid` and all three error flags read 0 on the following cycle, and the phase history returns to idle, so that the first cycle after reset counts as coming from idle.
- R2: The bus phase in each cycle is the 2-bit code {any select bit high, `bus_en`}. 00 is idle, 10 is setup, 11 is the data cycle and 01 is illegal.
- R3: A setup cycle with `bus_write`=1 produces a write record one clock later: `rec_valid`=1, `rec_write`=1, `rec_addr` and `rec_data` equal to the `bus_addr` and `bus_wdata` of that setup cycle.
- R4: A data cycle that directly follows a setup cycle, with `bus_write`=0, produces a read record one clock later. It has `rec_write`=0, `rec_data` equal to the `bus_rdata` of the data cycle, and the address and target index captured in the setup cycle.
- R5: The target index `rec_slave` is the position of the lowest set bit of `bus_sel` in the setup cycle.
- R6: `rec_valid` is high for exactly one cycle per record. Idle cycles, illegal cycles and data cycles with `bus_write`=1 produce no record.
- R7: `err_proto` pulses one clock after a cycle with phase code 01.
- R8: `err_stable` pulses one clock after a data cycle that follows a setup cycle when its `bus_addr` or `bus_write` differs from the setup cycle's value.
- R9: `err_seq` pulses one clock after a data cycle whose previous cycle was not a setup cycle. Such a data cycle yields no record.
- R10: `err_seq` pulses one clock after a setup cycle whose previous cycle was also a setup cycle. That second setup still captures its fields and, if it is a write, still yields a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Active-high synchronous reset |
| bus_sel | input | 8 | Target select vector (SEL_W) |
| bus_en | input | 1 | Data-cycle strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Address (ADDR_W) |
| bus_wdata | input | 8 | Write data (DATA_W) |
| bus_rdata | input | 8 | Read data (DATA_W) |
| rec_valid | output | 1 | One-cycle record strobe, no back-pressure |
| rec_write | output | 1 | Record direction |
| rec_addr | output | 8 | Record address |
| rec_data | output | 8 | Record data |
| rec_slave | output | 3 | Index of the selected target |
| err_proto | output | 1 | Illegal phase code seen |
| err_stable | output | 1 | Address or direction moved into the data cycle |
| err_seq | output | 1 | Illegal phase ordering seen |

## Verification
The properties assume that reset is held for at least one clock before the bus carries traffic. They also assume that every input is settled by the rising edge, because the phase is decoded straight from the sampled pins. The bench changes inputs only on falling edges and keeps reset high for several cycles. While reset is high it drives setup cycles on purpose, to show they leave no trace. Illegal codes, unstable fields and wrong orderings are applied on purpose, because flagging them is part of the block's function.

// File: rtl/bus_mon_pkg.sv
package bus_mon_pkg;
  // Phase code is {any select, enable}; the bit order is what the decoder builds.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_BAD   = 2'b01,
    PH_SETUP = 2'b10,
    PH_XFER  = 2'b11
  } phase_e;
endpackage

// File: rtl/bus_phase_decode.sv
module bus_phase_decode
  import bus_mon_pkg::*;
#(
  parameter int SEL_W = 8,
  parameter int ID_W  = $clog2(SEL_W)
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output phase_e           phase,
  output logic [ID_W-1:0]  slave_id
);
  localparam logic [ID_W-1:0] CLAMP_ID = ID_W'(SEL_W - 1);

  logic [SEL_W:0]   seen_below;
  logic [SEL_W-1:0] first_hit;

  assign seen_below[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < SEL_W; gi++) begin : g_scan
      assign first_hit[gi]    = sel[gi] & ~seen_below[gi];
      assign seen_below[gi+1] = seen_below[gi] | sel[gi];
    end
  endgenerate

  always_comb begin
    slave_id = '0;
    for (int i = 0; i < SEL_W; i++) begin
      if (first_hit[i]) slave_id = slave_id | ID_W'(i);
    end
    if (!seen_below[SEL_W]) slave_id = CLAMP_ID;
  end

  assign phase = phase_e'({seen_below[SEL_W], en});
endmodule

// File: rtl/bus_phase_tracker.sv
module bus_phase_tracker
  import bus_mon_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ID_W-1:0]   slave_id,
  output logic              after_setup,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [ID_W-1:0]   cap_id,
  output logic              err_proto,
  output logic              err_stable,
  output logic              err_seq
);
  phase_e prev_phase;
  logic   cap_write;
  logic   bad_code, moved, bad_order;

  assign after_setup = (prev_phase == PH_SETUP);

  always_comb begin
    bad_code  = (phase == PH_BAD);
    moved     = (phase == PH_XFER) && after_setup &&
                ((addr != cap_addr) || (write != cap_write));
    bad_order = ((phase == PH_XFER)  && !after_setup) ||
                ((phase == PH_SETUP) &&  after_setup);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_phase <= PH_IDLE;
      cap_addr   <= '0;
      cap_write  <= 1'b0;
      cap_id     <= '0;
      err_proto  <= 1'b0;
      err_stable <= 1'b0;
      err_seq    <= 1'b0;
    end else begin
      prev_phase <= phase;
      err_proto  <= bad_code;
      err_stable <= moved;
      err_seq    <= bad_order;
      if (phase == PH_SETUP) begin
        cap_addr  <= addr;
        cap_write <= write;
        cap_id    <= slave_id;
      end
    end
  end
endmodule

// File: rtl/bus_record_former.sv
module bus_record_former
  import bus_mon_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic              after_setup,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  input  logic [ID_W-1:0]   slave_id,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [ID_W-1:0]   cap_id,
  output logic              rec_valid,
  output logic              rec_write,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [DATA_W-1:0] rec_data,
  output logic [ID_W-1:0]   rec_slave
);
  logic emit_wr, emit_rd;

  always_comb begin
    emit_wr = (phase == PH_SETUP) && write;
    emit_rd = (phase == PH_XFER) && after_setup && !write;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;
      rec_write <= 1'b0;
      rec_addr  <= '0;
      rec_data  <= '0;
      rec_slave <= '0;
    end else begin
      rec_valid <= emit_wr | emit_rd;
      if (emit_wr) begin
        rec_write <= 1'b1;
        rec_addr  <= addr;
        rec_data  <= wdata;
        rec_slave <= slave_id;
      end else if (emit_rd) begin
        rec_write <= 1'b0;
        rec_addr  <= cap_addr;
        rec_data  <= rdata;
        rec_slave <= cap_id;
      end
    end
  end
endmodule

// File: rtl/bus_txn_monitor.sv
module bus_txn_monitor
  import bus_mon_pkg::*;
#(
  parameter int SEL_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int ID_W  = $clog2(SEL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic              bus_en,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rec_valid,
  output logic              rec_write,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [DATA_W-1:0] rec_data,
  output logic [ID_W-1:0]   rec_slave,
  output logic              err_proto,
  output logic              err_stable,
  output logic              err_seq
);
  phase_e            phase;
  logic [ID_W-1:0]   slave_id;
  logic              after_setup;
  logic [ADDR_W-1:0] cap_addr;
  logic [ID_W-1:0]   cap_id;

  bus_phase_decode #(.SEL_W(SEL_W), .ID_W(ID_W)) u_decode (
    .sel      (bus_sel),
    .en       (bus_en),
    .phase    (phase),
    .slave_id (slave_id)
  );

  bus_phase_tracker #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_track (
    .clk         (clk),
    .rst         (rst),
    .phase       (phase),
    .write       (bus_write),
    .addr        (bus_addr),
    .slave_id    (slave_id),
    .after_setup (after_setup),
    .cap_addr    (cap_addr),
    .cap_id      (cap_id),
    .err_proto   (err_proto),
    .err_stable  (err_stable),
    .err_seq     (err_seq)
  );

  bus_record_former #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_form (
    .clk         (clk),
    .rst         (rst),
    .phase       (phase),
    .after_setup (after_setup),
    .write       (bus_write),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .rdata       (bus_rdata),
    .slave_id    (slave_id),
    .cap_addr    (cap_addr),
    .cap_id      (cap_id),
    .rec_valid   (rec_valid),
    .rec_write   (rec_write),
    .rec_addr    (rec_addr),
    .rec_data    (rec_data),
    .rec_slave   (rec_slave)
  );
endmodule

// File: rtl/bus_txn_monitor_chk.sv
module bus_txn_monitor_chk #(
  parameter int SEL_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  bus_sel,
  input logic              bus_en,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rec_valid,
  input logic              rec_write,
  input logic [ADDR_W-1:0] rec_addr,
  input logic [DATA_W-1:0] rec_data,
  input logic [ID_W-1:0]   rec_slave,
  input logic              err_proto,
  input logic              err_stable,
  input logic              err_seq
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rec_valid && !err_proto && !err_stable && !err_seq));

  assert_write_record_R3: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_write) |->
      ($past(bus_sel != '0 && !bus_en && bus_write) &&
       rec_addr == $past(bus_addr) && rec_data == $past(bus_wdata)));

  assert_read_record_R4: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_write) |->
      ($past(bus_sel != '0 && bus_en && !bus_write) && rec_data == $past(bus_rdata)));

  assert_lowest_select_R5: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_write) |->
      ((($past(bus_sel) >> rec_slave) & SEL_W'(1)) == SEL_W'(1) &&
       ($past(bus_sel) & ~({SEL_W{1'b1}} << rec_slave)) == '0));

  assert_no_record_with_bad_code_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rec_valid, err_proto}));

  assert_proto_source_R7: assert property (@(posedge clk) disable iff (rst)
    err_proto |-> $past(bus_sel == '0 && bus_en));

  assert_stable_source_R8: assert property (@(posedge clk) disable iff (rst)
    err_stable |-> $past(bus_sel != '0 && bus_en));

  assert_seq_source_R9: assert property (@(posedge clk) disable iff (rst)
    err_seq |-> $past(bus_sel != '0));
endmodule

bind bus_txn_monitor bus_txn_monitor_chk #(
  .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_en(bus_en), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rec_valid(rec_valid), .rec_write(rec_write), .rec_addr(rec_addr),
  .rec_data(rec_data), .rec_slave(rec_slave), .err_proto(err_proto),
  .err_stable(err_stable), .err_seq(err_seq)
);

// File: tb/bus_txn_monitor_test.sv
module bus_txn_monitor_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_sel = '0;
  logic       bus_en = 1'b0;
  logic       bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata = '0;
  logic       rec_valid, rec_write, err_proto, err_stable, err_seq;
  logic [7:0] rec_addr, rec_data;
  logic [2:0] rec_slave;

  always #10 clk = ~clk;

  bus_txn_monitor uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_en(bus_en), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rec_valid(rec_valid), .rec_write(rec_write), .rec_addr(rec_addr),
    .rec_data(rec_data), .rec_slave(rec_slave), .err_proto(err_proto),
    .err_stable(err_stable), .err_seq(err_seq)
  );

  // Expected output: {valid, write, addr, data, slave, proto, stable, seq}
  typedef struct {
    logic [23:0] vec;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  // Reference state kept from the requirements
  logic [1:0] m_prev = 2'b00;
  logic [7:0] m_addr = '0;
  logic       m_wr = 1'b0;
  logic [2:0] m_id = '0;

  function automatic logic [2:0] lowest(input logic [7:0] s);
    for (int i = 0; i < 8; i++) if (s[i]) return 3'(i);
    return 3'd7;
  endfunction

  task automatic cyc(input logic r, input logic [7:0] s, input logic e, input logic w,
                     input logic [7:0] a, input logic [7:0] wd, input logic [7:0] rd);
    exp_t       it;
    logic [1:0] code;
    logic       v, vw, ep, es, eq;
    logic [7:0] va, vd;
    logic [2:0] vs;
    @(negedge clk);
    rst = r; bus_sel = s; bus_en = e; bus_write = w;
    bus_addr = a; bus_wdata = wd; bus_rdata = rd;
    @(posedge clk);
    {v, vw, ep, es, eq} = '0; va = '0; vd = '0; vs = '0;
    it.tag = "R6";
    code = {s != 8'h00, e};
    if (r) begin
      m_prev = 2'b00;
      it.tag = "R1";
    end else begin
      case (code)
        2'b01: begin ep = 1; it.tag = "R7"; end
        2'b10: begin
          if (m_prev == 2'b10) begin eq = 1; it.tag = "R10"; end
          m_addr = a; m_wr = w; m_id = lowest(s);
          if (w) begin
            v = 1; vw = 1; va = a; vd = wd; vs = m_id;
            if (!eq) it.tag = (s[0] ? "R3" : "R5");
          end
        end
        2'b11: begin
          if (m_prev != 2'b10) begin eq = 1; it.tag = "R9"; end
          else begin
            if (a != m_addr || w != m_wr) begin es = 1; it.tag = "R8"; end
            if (!w) begin
              v = 1; va = m_addr; vd = rd; vs = m_id;
              if (!es) it.tag = "R4";
            end
          end
        end
        default: it.tag = "R2";
      endcase
      m_prev = code;
    end
    it.vec = {v, vw, va, vd, vs, ep, es, eq};
    q.push_back(it);
  endtask

  // Monitor: one expected item per clock, compared after the edge settles
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t        it;
        logic [23:0] act, msk;
        it  = q.pop_front();
        act = {rec_valid, rec_write, rec_addr, rec_data, rec_slave,
               err_proto, err_stable, err_seq};
        msk = it.vec[23] ? 24'hFFFFFF : 24'h800007;
        n_chk++;
        if ((act & msk) !== (it.vec & msk)) begin
          n_bad++;
          $display("FAIL %s: actual %06h expected %06h", it.tag, act & msk, it.vec & msk);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: setup-write traffic under reset must leave no trace
    cyc(1, 8'h01, 0, 1, 8'h11, 8'h22, 8'h00);
    cyc(1, 8'h01, 1, 0, 8'h11, 8'h22, 8'h33);
    cyc(1, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00);
    cyc(0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00);
    // R3 write to target 0, then R6 the write data cycle produces nothing
    cyc(0, 8'h01, 0, 1, 8'h40, 8'hA5, 8'h00);
    cyc(0, 8'h01, 1, 1, 8'h40, 8'hA5, 8'h00);
    cyc(0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00);
    // R4 read from target 2 (R5 index)
    cyc(0, 8'h04, 0, 0, 8'h7E, 8'h00, 8'h00);
    cyc(0, 8'h04, 1, 0, 8'h7E, 8'h00, 8'hC3);
    // back-to-back: R5 lowest of 0x0A is 1, R5 top index 7
    cyc(0, 8'h0A, 0, 1, 8'h05, 8'h99, 8'h00);
    cyc(0, 8'h0A, 1, 1, 8'h05, 8'h99, 8'h00);
    cyc(0, 8'h80, 0, 0, 8'hF0, 8'h00, 8'h00);
    cyc(0, 8'h80, 1, 0, 8'hF0, 8'h00, 8'h5A);
    cyc(0, 8'h80, 0, 1, 8'hF1, 8'h3C, 8'h00);
    cyc(0, 8'h80, 1, 1, 8'hF1, 8'h3C, 8'h00);
    cyc(0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00);
    // R7 illegal code
    cyc(0, 8'h00, 1, 0, 8'h00, 8'h00, 8'h00);
    cyc(0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00);
    // R8 address moves on a read; record keeps setup address
    cyc(0, 8'h10, 0, 0, 8'h21, 8'h00, 8'h00);
    cyc(0, 8'h10, 1, 0, 8'h22, 8'h00, 8'h77);
    // R8 direction moves read -> write: flag, no record
    cyc(0, 8'h10, 0, 0, 8'h30, 8'h00, 8'h00);
    cyc(0, 8'h10, 1, 1, 8'h30, 8'h00, 8'h00);
    cyc(0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00);
    // R9 data cycle straight from idle: flag, no record
    cyc(0, 8'h02, 1, 0, 8'h44, 8'h00, 8'h66);
    cyc(0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00);
    // R10 setup held twice: both writes recorded, second flagged
    cyc(0, 8'h08, 0, 1, 8'h50, 8'h01, 8'h00);
    cyc(0, 8'h08, 0, 1, 8'h51, 8'h02, 8'h00);
    cyc(0, 8'h08, 1, 1, 8'h51, 8'h02, 8'h00);
    // R9 data cycle after data cycle
    cyc(0, 8'h08, 1, 0, 8'h51, 8'h00, 8'h12);
    cyc(0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00);
    // R1 reset between setup and data: history back to idle
    cyc(0, 8'h20, 0, 0, 8'h60, 8'h00, 8'h00);
    cyc(1, 8'h20, 1, 0, 8'h60, 8'h00, 8'h00);
    cyc(0, 8'h20, 1, 0, 8'h60, 8'h00, 8'h88);
    cyc(0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00);
    cyc(0, 8'h00, 0, 0, 8'h00, 8'h00, 8'h00);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule